// File: doc/BRIEF.md
# Host-Side Mailbox Port with Status Flags

This block sits between an external master processor and the local logic of a slave controller. The master sees two byte-wide mailboxes behind one chip select. A write strobe drops a byte into an inbound buffer. A read strobe either fetches the byte from a separate outbound buffer or returns an 8-bit status word, and the address line picks which of the two. Every host signal is brought into the local clock domain through a synchroniser. Flag updates are committed only once the host releases its strobe.

On the local side, logic pops the inbound byte, loads the outbound byte, and issues one-cycle opcodes. These opcodes rewrite the upper status nibble, manipulate a general-purpose flag, and switch a single port pin into flag-export mode. In that mode the pin can present the outbound-buffer-full flag to the master as an attention signal. Until then it behaves as a plain latched port bit.

Top module: `mshp_host_port`

## Requirements
- R1: After reset the status word is 0x00, both buffers hold 0x00, the pin is low, flag-export mode is off and the host bus is not driven (`host_doe` low).
- R2: Status layout is bit 0 outbound-full (OBF), bit 1 inbound-full (IBF), bit 2 user flag F0, bit 3 command/data flag F1, bits 7:4 user nibble. A completed host write with chip select low and address 0 stores the byte, sets IBF and clears F1.
- R3: A completed host write with address 1 sets IBF and sets F1, marking the byte as a command.
- R4: IBF, OBF and F1 do not change while a host strobe is held low. They change only after its rising edge.
- R5: A slave pop (`slv_in_rd`) clears IBF and leaves the inbound byte readable on `slv_in_data`.
- R6: A slave load of the outbound buffer sets OBF. A host read with address 0 returns that byte on `host_dout` with `host_doe` high, and clears OBF after the strobe is released.
- R7: A host read with address 1 returns the status word and changes no flag.
- R8: Slave opcode 0x90 copies bits 7:4 of `slv_cmd_arg` into status bits 7:4 in one cycle and leaves bits 3:0 unchanged.
- R9: Slave opcodes 0xA0, 0x85 and 0x95 set, clear and invert F0 respectively.
- R10: With flag-export mode off, the pin shows the last value written through `slv_port_wr`.
- R11: Slave opcode 0xF5 turns flag-export mode on until reset. In that mode, a port bit of 1 makes the pin follow OBF and a port bit of 0 holds the pin low.
- R12: Strobes with chip select high change no buffer or flag and leave `host_doe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_a0 | input | 1 | Host address: 0 data, 1 status/command |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| host_doe | output | 1 | Host bus drive enable |
| slv_in_rd | input | 1 | Slave pops inbound byte |
| slv_in_data | output | 8 | Inbound buffer contents |
| slv_out_ld | input | 1 | Slave loads outbound buffer |
| slv_out_data | input | 8 | Byte for outbound buffer |
| slv_cmd_vld | input | 1 | Slave opcode strobe |
| slv_cmd_op | input | 8 | Slave opcode |
| slv_cmd_arg | input | 8 | Opcode operand |
| slv_port_wr | input | 1 | Slave writes the port bit |
| slv_port_val | input | 1 | Port bit value |
| slv_status | output | 8 | Live status word |
| flag_pin | output | 1 | Port pin / exported OBF |

## Verification
The hardest situation to reach is the window in which a strobe has been low for many clocks but not yet released. That window is where a level-sensitive design would already have moved IBF. The bench holds the write strobe low for a long stretch and samples the slave-visible status during it, then releases the strobe and samples again. The status read is driven while OBF is pending, so that a flag change caused by a status read would be visible through `slv_status`.

// File: rtl/mshp_pkg.sv
package mshp_pkg;
  localparam int STS_OBF = 0;
  localparam int STS_IBF = 1;
  localparam int STS_F0  = 2;
  localparam int STS_F1  = 3;
  localparam logic [7:0] OP_STS_DEF  = 8'h90;
  localparam logic [7:0] OP_F0S_DEF  = 8'hA0;
  localparam logic [7:0] OP_F0C_DEF  = 8'h85;
  localparam logic [7:0] OP_F0T_DEF  = 8'h95;
  localparam logic [7:0] OP_FEN_DEF  = 8'hF5;
endpackage

// File: rtl/mshp_sync.sv
module mshp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = W * STAGES;
  logic [CW-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[CW-W-1:0], d};
      end
    end
  endgenerate

  assign q = chain[CW-1 -: W];
endmodule

// File: rtl/mshp_host_rx.sv
module mshp_host_rx #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          a0,
  input  logic [DW-1:0] din,
  output logic          wr_done,
  output logic          rd_done,
  output logic          sel_a0,
  output logic          rd_live,
  output logic          live_a0,
  output logic [DW-1:0] wdata
);
  logic [3:0] raw, syn;
  logic cs_s, rd_s, wr_s, a0_s;
  logic rd_prev, wr_prev, sel_q, a0_q;

  assign raw = {cs_n, rd_n, wr_n, a0};

  mshp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(syn)
  );

  assign {cs_s, rd_s, wr_s, a0_s} = syn;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev <= 1'b1;
      wr_prev <= 1'b1;
      sel_q   <= 1'b0;
      a0_q    <= 1'b0;
      wdata   <= '0;
    end else begin
      rd_prev <= rd_s;
      wr_prev <= wr_s;
      if (!rd_s || !wr_s) begin
        sel_q <= !cs_s;
        a0_q  <= a0_s;
      end
      if (!wr_s && !cs_s) wdata <= din;
    end
  end

  // commits fire on the synchronised trailing edge of a selected strobe
  assign wr_done = wr_s & ~wr_prev & sel_q;
  assign rd_done = rd_s & ~rd_prev & sel_q;
  assign sel_a0  = a0_q;
  assign rd_live = ~rd_s & ~cs_s;
  assign live_a0 = a0_s;
endmodule

// File: rtl/mshp_regs.sv
module mshp_regs
  import mshp_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [7:0] OP_STS = OP_STS_DEF,
  parameter logic [7:0] OP_F0S = OP_F0S_DEF,
  parameter logic [7:0] OP_F0C = OP_F0C_DEF,
  parameter logic [7:0] OP_F0T = OP_F0T_DEF,
  parameter logic [7:0] OP_FEN = OP_FEN_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_done,
  input  logic          rd_done,
  input  logic          sel_a0,
  input  logic          rd_live,
  input  logic          live_a0,
  input  logic [DW-1:0] wdata,
  input  logic          in_rd,
  input  logic          out_ld,
  input  logic [DW-1:0] out_data,
  input  logic          cmd_vld,
  input  logic [7:0]    cmd_op,
  input  logic [DW-1:0] cmd_arg,
  output logic [DW-1:0] in_data,
  output logic [DW-1:0] status,
  output logic          flags_en,
  output logic [DW-1:0] dout,
  output logic          doe
);
  localparam int HI = DW - 4;

  logic [DW-1:0] ibuf, obuf;
  logic          obf, ibf, f0, f1;
  logic [HI-1:0] st_hi;
  logic is_sts, is_f0s, is_f0c, is_f0t, is_fen;
  logic unused_arg_bits;

  assign unused_arg_bits = ^cmd_arg[3:0];

  assign is_sts = cmd_vld && (cmd_op == OP_STS);
  assign is_f0s = cmd_vld && (cmd_op == OP_F0S);
  assign is_f0c = cmd_vld && (cmd_op == OP_F0C);
  assign is_f0t = cmd_vld && (cmd_op == OP_F0T);
  assign is_fen = cmd_vld && (cmd_op == OP_FEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      ibuf <= '0; obuf <= '0;
      ibf <= 1'b0; obf <= 1'b0;
      f0 <= 1'b0; f1 <= 1'b0;
      st_hi <= '0; flags_en <= 1'b0;
    end else begin
      // inbound: host commit has priority over a same-cycle pop
      if (wr_done) begin
        ibuf <= wdata;
        ibf  <= 1'b1;
        f1   <= sel_a0;
      end else if (in_rd) begin
        ibf  <= 1'b0;
      end
      // outbound: fresh slave data has priority over a host drain
      if (out_ld) begin
        obuf <= out_data;
        obf  <= 1'b1;
      end else if (rd_done && !sel_a0) begin
        obf  <= 1'b0;
      end
      if (is_f0s)      f0 <= 1'b1;
      else if (is_f0c) f0 <= 1'b0;
      else if (is_f0t) f0 <= ~f0;
      if (is_sts) st_hi <= cmd_arg[DW-1:4];
      if (is_fen) flags_en <= 1'b1;
    end
  end

  always_comb begin
    status = '0;
    status[STS_OBF] = obf;
    status[STS_IBF] = ibf;
    status[STS_F0]  = f0;
    status[STS_F1]  = f1;
    status[DW-1:4]  = st_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      doe  <= 1'b0;
    end else begin
      doe <= rd_live;
      if (rd_live) dout <= live_a0 ? status : obuf;
    end
  end

  assign in_data = ibuf;
endmodule

// File: rtl/mshp_pin.sv
module mshp_pin (
  input  logic clk,
  input  logic rst,
  input  logic port_wr,
  input  logic port_val,
  input  logic flags_en,
  input  logic obf,
  output logic port_bit,
  output logic pin
);
  always_ff @(posedge clk) begin
    if (rst) begin
      port_bit <= 1'b0;
      pin      <= 1'b0;
    end else begin
      if (port_wr) port_bit <= port_val;
      pin <= flags_en ? (port_bit & obf) : port_bit;
    end
  end
endmodule

// File: rtl/mshp_host_port.sv
module mshp_host_port
  import mshp_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] OP_STS = OP_STS_DEF,
  parameter logic [7:0] OP_F0S = OP_F0S_DEF,
  parameter logic [7:0] OP_F0C = OP_F0C_DEF,
  parameter logic [7:0] OP_F0T = OP_F0T_DEF,
  parameter logic [7:0] OP_FEN = OP_FEN_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_cs_n,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic          host_a0,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic          host_doe,
  input  logic          slv_in_rd,
  output logic [DW-1:0] slv_in_data,
  input  logic          slv_out_ld,
  input  logic [DW-1:0] slv_out_data,
  input  logic          slv_cmd_vld,
  input  logic [7:0]    slv_cmd_op,
  input  logic [DW-1:0] slv_cmd_arg,
  input  logic          slv_port_wr,
  input  logic          slv_port_val,
  output logic [DW-1:0] slv_status,
  output logic          flag_pin
);
  logic          wr_done, rd_done, sel_a0, rd_live, live_a0;
  logic [DW-1:0] wdata;
  logic          flags_en, port_bit;

  mshp_host_rx #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst),
    .cs_n(host_cs_n), .rd_n(host_rd_n), .wr_n(host_wr_n), .a0(host_a0),
    .din(host_din),
    .wr_done(wr_done), .rd_done(rd_done), .sel_a0(sel_a0),
    .rd_live(rd_live), .live_a0(live_a0), .wdata(wdata)
  );

  mshp_regs #(
    .DW(DW), .OP_STS(OP_STS), .OP_F0S(OP_F0S), .OP_F0C(OP_F0C),
    .OP_F0T(OP_F0T), .OP_FEN(OP_FEN)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_done(wr_done), .rd_done(rd_done), .sel_a0(sel_a0),
    .rd_live(rd_live), .live_a0(live_a0), .wdata(wdata),
    .in_rd(slv_in_rd), .out_ld(slv_out_ld), .out_data(slv_out_data),
    .cmd_vld(slv_cmd_vld), .cmd_op(slv_cmd_op), .cmd_arg(slv_cmd_arg),
    .in_data(slv_in_data), .status(slv_status), .flags_en(flags_en),
    .dout(host_dout), .doe(host_doe)
  );

  mshp_pin u_pin (
    .clk(clk), .rst(rst),
    .port_wr(slv_port_wr), .port_val(slv_port_val),
    .flags_en(flags_en), .obf(slv_status[STS_OBF]),
    .port_bit(port_bit), .pin(flag_pin)
  );
endmodule

// File: rtl/mshp_chk.sv
module mshp_chk #(
  parameter int DW = 8,
  parameter logic [7:0] OP_STS = 8'h90
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_done,
  input logic          rd_done,
  input logic          sel_a0,
  input logic [DW-1:0] status,
  input logic          cmd_vld,
  input logic [7:0]    cmd_op,
  input logic [DW-1:0] cmd_arg,
  input logic          flags_en,
  input logic          port_bit,
  input logic          flag_pin
);
  // R8
  sts_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd_op == OP_STS) |=> status[DW-1:4] == $past(cmd_arg[DW-1:4]));
  // R4
  ibf_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status[1]) |-> $past(wr_done));
  // R6
  obf_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(status[0]) |-> $past(rd_done && !sel_a0));
  // R3
  f1_track_chk: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> status[3] == $past(sel_a0));
  // R10
  pin_port_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(flags_en) |-> flag_pin == $past(port_bit));
  // R11
  pin_mask_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flags_en && !port_bit) |-> !flag_pin);
  // R11
  pin_obf_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flags_en && port_bit) |-> flag_pin == $past(status[0]));
endmodule

bind mshp_host_port mshp_chk #(.DW(DW), .OP_STS(OP_STS)) u_chk (
  .clk(clk), .rst(rst), .wr_done(wr_done), .rd_done(rd_done),
  .sel_a0(sel_a0), .status(slv_status), .cmd_vld(slv_cmd_vld),
  .cmd_op(slv_cmd_op), .cmd_arg(slv_cmd_arg), .flags_en(flags_en),
  .port_bit(port_bit), .flag_pin(flag_pin)
);

// File: tb/mshp_host_port_test.sv
`timescale 1ns/1ps
module mshp_host_port_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic doe;
  logic in_rd = 1'b0, out_ld = 1'b0, cmd_vld = 1'b0, port_wr = 1'b0, port_val = 1'b0;
  logic [7:0] in_data, out_data = 8'h00, cmd_op = 8'h00, cmd_arg = 8'h00, status;
  logic pin;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mshp_host_port uut (
    .clk(clk), .rst(rst), .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
    .host_a0(a0), .host_din(din), .host_dout(dout), .host_doe(doe),
    .slv_in_rd(in_rd), .slv_in_data(in_data), .slv_out_ld(out_ld),
    .slv_out_data(out_data), .slv_cmd_vld(cmd_vld), .slv_cmd_op(cmd_op),
    .slv_cmd_arg(cmd_arg), .slv_port_wr(port_wr), .slv_port_val(port_val),
    .slv_status(status), .flag_pin(pin)
  );

  // kind 0 host write, 1 slave opcode, 2 slave load + host data read
  // fields: kind[26:25] a0[24] val/op[23:16] arg[15:8] expected status[7:0]
  localparam int NV = 11;
  localparam logic [26:0] VEC [NV] = '{
    {2'd0, 1'b0, 8'h3C, 8'h00, 8'h02},
    {2'd0, 1'b1, 8'hA5, 8'h00, 8'h0A},
    {2'd1, 1'b0, 8'h90, 8'h5F, 8'h58},
    {2'd1, 1'b0, 8'hA0, 8'h00, 8'h5C},
    {2'd2, 1'b0, 8'h77, 8'h00, 8'h5D},
    {2'd1, 1'b0, 8'h95, 8'h00, 8'h58},
    {2'd0, 1'b0, 8'h00, 8'h00, 8'h52},
    {2'd1, 1'b0, 8'h90, 8'hA3, 8'hA0},
    {2'd1, 1'b0, 8'hA0, 8'h00, 8'hA4},
    {2'd1, 1'b0, 8'h85, 8'h00, 8'hA0},
    {2'd1, 1'b0, 8'h95, 8'h00, 8'hA4}
  };

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic host_write(input logic adr, input logic [7:0] d);
    cs_n = 1'b0; a0 = adr; din = d; wr_n = 1'b0;
    waitc(5);
    wr_n = 1'b1;
    waitc(5);
    cs_n = 1'b1;
    waitc(1);
  endtask

  task automatic host_read(input logic adr, output logic [7:0] d, output logic oe);
    cs_n = 1'b0; a0 = adr; rd_n = 1'b0;
    waitc(6);
    d = dout; oe = doe;
    rd_n = 1'b1;
    waitc(5);
    cs_n = 1'b1;
    waitc(2);
  endtask

  task automatic slave_op(input logic [7:0] op, input logic [7:0] arg);
    cmd_vld = 1'b1; cmd_op = op; cmd_arg = arg;
    waitc(1);
    cmd_vld = 1'b0;
    waitc(1);
  endtask

  task automatic pulse_pop();
    in_rd = 1'b1; waitc(1); in_rd = 1'b0; waitc(1);
  endtask

  task automatic slave_load(input logic [7:0] d);
    out_ld = 1'b1; out_data = d; waitc(1); out_ld = 1'b0; waitc(1);
  endtask

  task automatic port_set(input logic v);
    port_wr = 1'b1; port_val = v; waitc(1); port_wr = 1'b0; waitc(2);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] rd;
    logic oe;
    waitc(4);
    rst = 1'b0;
    waitc(2);
    // R1 reset state
    chk("R1 status", status, 8'h00);
    chk("R1 pin", {7'd0, pin}, 8'h00);
    chk("R1 doe", {7'd0, doe}, 8'h00);
    chk("R1 inbound", in_data, 8'h00);
    host_read(1'b0, rd, oe);
    chk("R1 outbound", rd, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0] kind;
      logic [7:0] exp, st;
      kind = VEC[i][26:25];
      exp = VEC[i][7:0];
      case (kind)
        2'd0: begin
          host_write(VEC[i][24], VEC[i][23:16]);
          chk(VEC[i][24] ? "R3 status" : "R2 status", status, exp);
          chk("R2 inbound byte", in_data, VEC[i][23:16]);
          host_read(1'b1, st, oe);
          chk("R7 host status", st, exp);
          pulse_pop();
          chk("R5 pop", status, exp & 8'hFD);
          chk("R5 byte kept", in_data, VEC[i][23:16]);
        end
        2'd1: begin
          slave_op(VEC[i][23:16], VEC[i][15:8]);
          chk(VEC[i][23:16] == 8'h90 ? "R8 nibble" : "R9 F0", status, exp);
        end
        default: begin
          slave_load(VEC[i][23:16]);
          chk("R6 obf set", status, exp);
          host_read(1'b1, st, oe);
          chk("R7 status read", st, exp);
          chk("R7 no change", status, exp);
          host_read(1'b0, rd, oe);
          chk("R6 data", rd, VEC[i][23:16]);
          chk("R6 doe", {7'd0, oe}, 8'h01);
          chk("R6 obf clear", status, exp & 8'hFE);
        end
      endcase
    end

    // R4: strobe held low leaves flags alone
    slave_op(8'h90, 8'h00);
    slave_op(8'h85, 8'h00);
    cs_n = 1'b0; a0 = 1'b1; din = 8'hC3; wr_n = 1'b0;
    waitc(20);
    chk("R4 held low", status, 8'h00);
    wr_n = 1'b1;
    waitc(5);
    chk("R4 after release", status, 8'h0A);
    cs_n = 1'b1;
    waitc(1);
    pulse_pop();
    chk("R5 clear", status, 8'h08);

    // R12: deselected strobes are ignored
    cs_n = 1'b1; a0 = 1'b0; din = 8'h11; wr_n = 1'b0;
    waitc(5); wr_n = 1'b1; waitc(5);
    chk("R12 no write flag", status, 8'h08);
    chk("R12 inbound kept", in_data, 8'hC3);
    rd_n = 1'b0; waitc(6);
    chk("R12 bus idle", {7'd0, doe}, 8'h00);
    rd_n = 1'b1; waitc(3);

    // R10 plain port mode
    port_set(1'b1);
    chk("R10 pin high", {7'd0, pin}, 8'h01);
    port_set(1'b0);
    chk("R10 pin low", {7'd0, pin}, 8'h00);
    slave_load(8'h5A);
    port_set(1'b1);
    chk("R10 ignores obf", {7'd0, pin}, 8'h01);
    host_read(1'b0, rd, oe);
    chk("R10 still port", {7'd0, pin}, 8'h01);

    // R11 flag-export mode
    slave_op(8'hF5, 8'h00);
    waitc(1);
    chk("R11 follows obf low", {7'd0, pin}, 8'h00);
    slave_load(8'h66);
    waitc(1);
    chk("R11 follows obf high", {7'd0, pin}, 8'h01);
    port_set(1'b0);
    chk("R11 masked", {7'd0, pin}, 8'h00);
    port_set(1'b1);
    chk("R11 unmasked", {7'd0, pin}, 8'h01);
    host_read(1'b0, rd, oe);
    waitc(1);
    chk("R11 drained", {7'd0, pin}, 8'h00);
    chk("R6 drained data", rd, 8'h66);

    finish_up();
  end
endmodule